// File: doc/BRIEF.md
# Software Timer Interrupt Unit

This block is a periodic countdown timer that a host programs through a small register port. The host writes a 6-bit period value. The timer counts down by one on each pulse of the `tick` input. When the count is already zero, the next tick raises a sticky status flag, and the counter loads the period value again and keeps running. The flag drives the interrupt output only while the host has set the enable bit. The host clears the flag by writing a one to it.

The block has three resets and holds. `rst_n` is the hard reset and clears everything. `soft_rst` and `stop` hold the counter at the programmed period and leave the flag, the enable bit and the period untouched. The tick source and any further interrupt merging sit outside the block. The register port has no handshake. A write takes effect at the next rising clock edge. A read is combinational from `rd_addr`.

Top module: `stmr_unit`

## Requirements
- R1: After hard reset (`rst_n` low), the enable bit, the status flag, the period register and the counter are all 0, and `irq_o` is 0.
- R2: The period register is at address 1 and uses `wr_data[5:0]`; higher bits are dropped and read back as 0. A write to it also loads the counter with the new value at once, and a tick in the same cycle is ignored.
- R3: A tick while the counter is nonzero, and no hold or period write is active, decreases the counter by exactly one. The counter can be read at address 3. Without a tick, the counter does not change.
- R4: A tick while the counter is 0 sets the status flag and reloads the counter from the period register. The flag is therefore set once every N+1 ticks for a period of N. A period of 0 sets it on every tick.
- R5: The enable bit is bit 0 at address 0. `irq_o` is 1 exactly when both the status flag and the enable bit are 1.
- R6: The status flag is bit 0 at address 2. Writing 1 there clears it, and writing 0 leaves it unchanged.
- R7: If a clear write and an expiry happen in the same cycle, the status flag stays set.
- R8: While `soft_rst` or `stop` is high, the counter holds the period value and ticks have no effect. The status flag, the enable bit and the period register keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Hard reset, active low, asynchronous |
| soft_rst | input | 1 | Soft reset: holds the counter at the period value |
| stop | input | 1 | Stop: holds the counter at the period value |
| tick | input | 1 | Count-enable pulse, one decrement per cycle high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data for `rd_addr` (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is a clear write that lands in the same cycle as an expiry (R7). Reaching it from the ports requires a known counter phase. The stimulus first programs a period of 0, which makes every tick an expiry. It then drives the clear write and a tick in one cycle, so the collision happens on demand. A second hard case is a tick that coincides with a period write or a held counter. The bench reaches it by asserting those inputs together in one vector and reading back the counter through address 3.

// File: rtl/stmr_pkg.sv
package stmr_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 2'd0,
    A_PERIOD = 2'd1,
    A_STAT   = 2'd2,
    A_COUNT  = 2'd3
  } stmr_addr_e;
endpackage

// File: rtl/stmr_count.sv
module stmr_count #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             hold,
  input  logic [CNT_W-1:0] period,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ZERO = '0;
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  logic             active;
  logic             at_zero;
  logic [CNT_W-1:0] cnt_d;

  assign active  = tick && !hold && !load;
  assign at_zero = (cnt == ZERO);
  assign expire  = active && at_zero;

  always_comb begin
    cnt_d = cnt;
    if (load)             cnt_d = load_val;
    else if (hold)        cnt_d = period;
    else if (expire)      cnt_d = period;
    else if (active)      cnt_d = cnt - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= ZERO;
    else        cnt <= cnt_d;
  end

  // R3: a plain tick steps the counter down by one
  p_step_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !load && cnt != ZERO) |=> (cnt == $past(cnt) - ONE));

  // R3: with no tick, hold or load, the counter is stable
  p_idle_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !hold && !load) |=> $stable(cnt));

  // R4: expiry reloads the period value
  p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !hold && !load && cnt == ZERO) |=> (cnt == $past(period)));

  // R8: hold parks the counter on the period value
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !load) |=> (cnt == $past(period)));

  // R2: a period write loads the counter regardless of tick
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt == $past(load_val)));
endmodule

// File: rtl/stmr_flag.sv
module stmr_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  input  logic en,
  output logic sts,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts <= 1'b0;
    else if (expire) sts <= 1'b1;
    else if (clr)    sts <= 1'b0;
  end

  assign irq = sts & en;

  // R4: expiry always leaves the flag set
  p_sticky_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> sts);

  // R7: a clear that collides with an expiry loses
  p_collide_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && clr) |=> sts);

  // R6: a clear with no expiry drops the flag
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !sts);

  // R8: without expiry or clear the flag keeps its value
  p_flag_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !expire) |=> $stable(sts));

  // R5: no interrupt without enable
  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en && sts));
endmodule

// File: rtl/stmr_regs.sv
module stmr_regs
  import stmr_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              sts,
  input  logic [CNT_W-1:0]  cnt,
  output logic              en,
  output logic [CNT_W-1:0]  period,
  output logic              period_we,
  output logic [CNT_W-1:0]  period_new,
  output logic              clr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int PAD_W = DATA_W - CNT_W;

  logic unused_hi;
  assign unused_hi = ^wr_data[DATA_W-1:CNT_W];

  logic ctrl_we;
  assign ctrl_we    = wr_en && (wr_addr == A_CTRL);
  assign period_we  = wr_en && (wr_addr == A_PERIOD);
  assign clr        = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign period_new = wr_data[CNT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en     <= 1'b0;
      period <= '0;
    end else begin
      if (ctrl_we)   en     <= wr_data[0];
      if (period_we) period <= period_new;
    end
  end

  always_comb begin
    unique case (stmr_addr_e'(rd_addr))
      A_CTRL:   rd_data = {{(DATA_W-1){1'b0}}, en};
      A_PERIOD: rd_data = {{PAD_W{1'b0}}, period};
      A_STAT:   rd_data = {{(DATA_W-1){1'b0}}, sts};
      A_COUNT:  rd_data = {{PAD_W{1'b0}}, cnt};
      default:  rd_data = '0;
    endcase
  end

  // R8: enable and period change only through writes
  p_cfg_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(en) && $stable(period)));

  // R2: a period write lands masked to the field width
  p_period_wr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    period_we |=> (period == $past(wr_data[CNT_W-1:0])));
endmodule

// File: rtl/stmr_unit.sv
module stmr_unit
  import stmr_pkg::*;
#(
  parameter int CNT_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              stop,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_o
);
  logic             en, sts, clr, expire, period_we, hold;
  logic [CNT_W-1:0] period, period_new, cnt;

  assign hold = soft_rst | stop;

  stmr_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .sts(sts), .cnt(cnt),
    .en(en), .period(period), .period_we(period_we),
    .period_new(period_new), .clr(clr), .rd_data(rd_data)
  );

  stmr_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .load(period_we), .load_val(period_new),
    .hold(hold), .period(period), .tick(tick), .cnt(cnt), .expire(expire)
  );

  stmr_flag u_flag (
    .clk(clk), .rst_n(rst_n), .expire(expire), .clr(clr), .en(en),
    .sts(sts), .irq(irq_o)
  );

  // R1: coming out of hard reset nothing is pending
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |=> !irq_o);
endmodule

// File: tb/test_stmr_unit.sv
module test_stmr_unit;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       soft_rst = 1'b0, stop = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [1:0] wr_addr = '0, rd_addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       irq_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stmr_unit i_stmr_unit (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .tick(tick),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .irq_o(irq_o)
  );

  typedef struct packed {
    logic       we;
    logic [1:0] wa;
    logic [7:0] wd;
    logic       tk;
    logic [1:0] ra;
    logic [7:0] er;
    logic       ei;
    logic [3:0] rq;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 2'd1, 8'h03, 1'b0, 2'd3, 8'h03, 1'b0, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd3, 8'h02, 1'b0, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd3, 8'h01, 1'b0, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd3, 8'h00, 1'b0, 4'd3},
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 8'h01, 1'b0, 4'd4},
    '{1'b1, 2'd0, 8'h01, 1'b0, 2'd0, 8'h01, 1'b1, 4'd5},
    '{1'b1, 2'd2, 8'h00, 1'b0, 2'd2, 8'h01, 1'b1, 4'd6},
    '{1'b1, 2'd2, 8'h01, 1'b0, 2'd2, 8'h00, 1'b0, 4'd6},
    '{1'b1, 2'd1, 8'hFF, 1'b0, 2'd1, 8'h3F, 1'b0, 4'd2},
    '{1'b1, 2'd1, 8'h00, 1'b1, 2'd3, 8'h00, 1'b0, 4'd2},
    '{1'b0, 2'd0, 8'h00, 1'b1, 2'd2, 8'h01, 1'b1, 4'd4},
    '{1'b1, 2'd2, 8'h01, 1'b1, 2'd2, 8'h01, 1'b1, 4'd7},
    '{1'b1, 2'd2, 8'h01, 1'b0, 2'd2, 8'h00, 1'b0, 4'd6},
    '{1'b1, 2'd0, 8'h00, 1'b0, 2'd0, 8'h00, 1'b0, 4'd5}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, input string req, input logic [7:0] exp);
    rd_addr = a;
    #1;
    check(req, rd_data, exp);
  endtask

  task automatic cycle(input logic we, input logic [1:0] wa, input logic [7:0] wd,
                       input logic tk);
    wr_en = we; wr_addr = wa; wr_data = wd; tick = tk;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(2'd0, "R1", 8'h00); rd(2'd1, "R1", 8'h00);
    rd(2'd2, "R1", 8'h00); rd(2'd3, "R1", 8'h00);
    check("R1", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      cycle(VECS[i].we, VECS[i].wa, VECS[i].wd, VECS[i].tk);
      rd(VECS[i].ra, $sformatf("R%0d", VECS[i].rq), VECS[i].er);
      check($sformatf("R%0d irq", VECS[i].rq), {7'd0, irq_o}, {7'd0, VECS[i].ei});
    end

    // R2: period write with a tick in the same cycle loads exactly
    cycle(1'b1, 2'd1, 8'h02, 1'b1);
    rd(2'd3, "R2", 8'h02);

    // R8: soft reset and stop hold the counter, keep flag/enable/period
    cycle(1'b1, 2'd1, 8'h00, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    cycle(1'b1, 2'd0, 8'h01, 1'b0);
    cycle(1'b1, 2'd1, 8'h05, 1'b0);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    rd(2'd3, "R3", 8'h03);
    soft_rst = 1'b1;
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    soft_rst = 1'b0;
    rd(2'd3, "R8 soft", 8'h05);
    rd(2'd2, "R8 soft", 8'h01);
    rd(2'd0, "R8 soft", 8'h01);
    rd(2'd1, "R8 soft", 8'h05);
    check("R8 irq", {7'd0, irq_o}, 8'h01);
    stop = 1'b1;
    for (int k = 0; k < 3; k++) cycle(1'b0, 2'd0, 8'h00, 1'b1);
    rd(2'd3, "R8 stop", 8'h05);
    rd(2'd2, "R8 stop", 8'h01);
    stop = 1'b0;
    // R4: period 5 expires after 6 ticks
    for (int k = 0; k < 5; k++) cycle(1'b0, 2'd0, 8'h00, 1'b1);
    cycle(1'b1, 2'd2, 8'h01, 1'b0);
    rd(2'd3, "R4", 8'h00);
    rd(2'd2, "R4", 8'h00);
    cycle(1'b0, 2'd0, 8'h00, 1'b1);
    rd(2'd2, "R4", 8'h01);
    rd(2'd3, "R4", 8'h05);

    // R1: hard reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rd(2'd0, "R1", 8'h00); rd(2'd1, "R1", 8'h00);
    rd(2'd2, "R1", 8'h00); rd(2'd3, "R1", 8'h00);
    check("R1 irq", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule